// File: doc/BRIEF.md
# Shared-Bus RAM/ROM Access Controller

This block sits on the host side of an external memory part that holds a small static RAM and a larger one-time-programmable ROM. Both arrays share the address lines, the 8-bit data bus and a single output strobe, and each array has its own chip-select. The host issues single synchronous requests. Each request names a region (RAM or ROM), an address, a direction and, for writes, a data byte. The controller plays the asynchronous strobe sequence for that request and uses one countdown timer to set every phase length in clock ticks. It captures the byte that comes back on reads and signals the end of the request with a one-cycle completion pulse.

Every timing limit of the memory is a parameter in nanoseconds. The clock period is also a parameter. Each limit is converted to whole cycles and rounded up. The two chip-selects are never low in the same cycle. A write aimed at the ROM region is refused at once with an error flag and does not touch the bus. The data bus is split into an output, an output-enable and an input, so a pad ring can build the tri-state buffer. Address, data and region are latched when a request is accepted and stay constant until the request completes.

The sequencer has seven states:
- **IDLE**: waits for a request.
- **RD_ACT**: the read strobes are active.
- **WR_GAP**: bus turnaround before write data is driven.
- **WR_PULSE**: the write strobe is active.
- **WR_HOLD**: write recovery, with data still driven and the strobes released.
- **FINISH**: the completion pulse.
- **REJECT**: a refused ROM write.

The transitions are:
- IDLE→REJECT on a ROM write.
- IDLE→WR_GAP on a RAM write.
- IDLE→RD_ACT on any read.
- RD_ACT→FINISH, WR_GAP→WR_PULSE, WR_PULSE→WR_HOLD and WR_HOLD→FINISH, each when the timer expires.
- FINISH→IDLE and REJECT→IDLE, unconditionally.

Top module: `dualmem_bus_ctrl`

## Requirements
- R1: After reset and whenever idle, the block holds RAM select, ROM select, write strobe and output strobe high (all four are active low). It leaves the data bus undriven (`dq_oe`=0), holds `req_ready` at 1, and holds `done` and `err` at 0.
- R2: RAM select and ROM select are never low in the same cycle.
- R3: A RAM read holds RAM select low, output strobe low, ROM select high and write strobe high for ceil(max(t_rc, t_acc)/clk) cycles, 10 by default. During any RAM access, `mem_addr` bits 19..17 are 0 and bits 16..0 equal the request address.
- R4: A ROM read holds ROM select low, output strobe low and RAM select high for the same number of cycles as a RAM read, and places all 20 request address bits on `mem_addr`.
- R5: Read data is sampled from `dq_in` on the last cycle the read strobes are low. It is presented on `rdata` with `done`, in the cycle right after the strobes are released, which is the 11th cycle after the accepting edge by default.
- R6: A RAM write first spends ceil(t_hz/clk) cycles (4) with all strobes high and the bus undriven. It then drives data with RAM select and write strobe low and output strobe high for max(ceil(t_wp/clk), ceil(t_ds/clk)) cycles (8). It then keeps data and address for the rest of ceil(t_wc/clk) (2 cycles). `done` follows, in the 15th cycle after acceptance.
- R7: A write with the ROM region selected raises `done` and `err` together in the first cycle after acceptance. It toggles no strobe and never drives the bus. The ROM select is never low while the write strobe is low.
- R8: A request is accepted only while `req_ready` is 1, which is only in IDLE. `req_ready` stays 0 from the accepting edge until after `done`. A `req_valid` while busy has no effect.
- R9: `done` lasts exactly one cycle per accepted request. `err` is never high without `done`.
- R10: Each timing value is converted to cycles by rounding up. With a 10 ns clock, a 75 ns write pulse becomes 8 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_rom | input | 1 | Region: 1 = ROM, 0 = RAM |
| req_addr | input | 20 | Request address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Idle and able to accept |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request refused (with done) |
| rdata | output | 8 | Last byte read |
| mem_addr | output | 20 | Address lines to the memory |
| ram_ce_n | output | 1 | RAM select, active low |
| rom_ce_n | output | 1 | ROM select, active low |
| we_n | output | 1 | Write strobe, active low |
| oe_n | output | 1 | Output strobe, active low |
| dq_out | output | 8 | Byte to drive on the data bus |
| dq_oe | output | 1 | Drive enable for dq_out |
| dq_in | input | 8 | Byte sampled from the data bus |

## Verification
Each completion is due a fixed number of cycles after the accepting edge: 11 for reads, 15 for RAM writes and 1 for refused ROM writes. The scoreboard records the issue cycle with every expected item and compares the cycle in which `done` arrives against that figure. Strobe phases are measured by run-length counters sampled on falling clock edges: the output strobe must stay low for 10 cycles and the write strobe for 8. The quiet interval before `dq_oe` rises must reach at least 4 cycles. Read data is compared only in the `done` cycle, which falls one cycle after the sampling edge.

// File: rtl/dualmem_pkg.sv
package dualmem_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_ACT,
        S_WR_GAP,
        S_WR_PULSE,
        S_WR_HOLD,
        S_FINISH,
        S_REJECT
    } dm_state_e;

    // Nanoseconds to whole clock cycles, rounded up, never below one.
    function automatic int ns_to_cycles(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dm_cycle_timer.sv
module dm_cycle_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/dm_seq_fsm.sv
module dm_seq_fsm
    import dualmem_pkg::*;
#(
    parameter int RD_CYC    = 10,
    parameter int GAP_CYC   = 4,
    parameter int PULSE_CYC = 8,
    parameter int HOLD_CYC  = 2,
    parameter int CNT_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             req_rom,
    input  logic             t_expired,
    output dm_state_e        state,
    output logic             t_load,
    output logic [CNT_W-1:0] t_val
);

    localparam logic [CNT_W-1:0] RD_LD    = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] GAP_LD   = CNT_W'(GAP_CYC - 1);
    localparam logic [CNT_W-1:0] PULSE_LD = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LD  = CNT_W'(HOLD_CYC - 1);

    dm_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt    = state;
        t_load = 1'b0;
        t_val  = '0;
        unique case (state)
            S_IDLE: begin
                if (req_valid) begin
                    if (req_write && req_rom) begin
                        nxt = S_REJECT;
                    end else if (req_write) begin
                        nxt    = S_WR_GAP;
                        t_load = 1'b1;
                        t_val  = GAP_LD;
                    end else begin
                        nxt    = S_RD_ACT;
                        t_load = 1'b1;
                        t_val  = RD_LD;
                    end
                end
            end
            S_RD_ACT: begin
                if (t_expired) nxt = S_FINISH;
            end
            S_WR_GAP: begin
                if (t_expired) begin
                    nxt    = S_WR_PULSE;
                    t_load = 1'b1;
                    t_val  = PULSE_LD;
                end
            end
            S_WR_PULSE: begin
                if (t_expired) begin
                    nxt    = S_WR_HOLD;
                    t_load = 1'b1;
                    t_val  = HOLD_LD;
                end
            end
            S_WR_HOLD: begin
                if (t_expired) nxt = S_FINISH;
            end
            S_FINISH: nxt = S_IDLE;
            S_REJECT: nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    AST_READ_HELD_UNTIL_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RD_ACT && !t_expired) |=> (state == S_RD_ACT)); // R3

    AST_REJECT_ONLY_ROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_REJECT) |-> ($past(state) == S_IDLE && $past(req_write) && $past(req_rom))); // R7

endmodule

// File: rtl/dm_strobe_decode.sv
module dm_strobe_decode
    import dualmem_pkg::*;
(
    input  dm_state_e state,
    input  logic      rom_sel,
    output logic      ram_ce_n,
    output logic      rom_ce_n,
    output logic      we_n,
    output logic      oe_n,
    output logic      bus_drive
);

    logic rd_phase;
    logic wr_phase;

    always_comb begin
        rd_phase  = (state == S_RD_ACT);
        wr_phase  = (state == S_WR_PULSE);
        ram_ce_n  = !((rd_phase || wr_phase) && !rom_sel);
        rom_ce_n  = !(rd_phase && rom_sel);
        we_n      = !wr_phase;
        oe_n      = !rd_phase;
        bus_drive = wr_phase || (state == S_WR_HOLD);
    end

endmodule

// File: rtl/dualmem_bus_ctrl.sv
module dualmem_bus_ctrl
    import dualmem_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int ADDR_W     = 20,
    parameter int RAM_ADDR_W = 17,
    parameter int CLK_NS     = 10,
    parameter int T_RC_NS    = 100,
    parameter int T_ACC_NS   = 100,
    parameter int T_WC_NS    = 100,
    parameter int T_WP_NS    = 75,
    parameter int T_DS_NS    = 40,
    parameter int T_HZ_NS    = 35
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_rom,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              ram_ce_n,
    output logic              rom_ce_n,
    output logic              we_n,
    output logic              oe_n,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    input  logic [DATA_W-1:0] dq_in
);

    localparam int RD_CYC    = max2(ns_to_cycles(T_RC_NS, CLK_NS), ns_to_cycles(T_ACC_NS, CLK_NS));
    localparam int GAP_CYC   = ns_to_cycles(T_HZ_NS, CLK_NS);
    localparam int PULSE_CYC = max2(ns_to_cycles(T_WP_NS, CLK_NS), ns_to_cycles(T_DS_NS, CLK_NS));
    localparam int WC_CYC    = ns_to_cycles(T_WC_NS, CLK_NS);
    localparam int HOLD_CYC  = (WC_CYC > PULSE_CYC) ? (WC_CYC - PULSE_CYC) : 1;
    localparam int MAX_CYC   = max2(max2(RD_CYC, GAP_CYC), max2(PULSE_CYC, HOLD_CYC));
    localparam int CNT_W     = $clog2(MAX_CYC + 1);
    localparam logic [ADDR_W-1:0] RAM_MASK =
        {{(ADDR_W-RAM_ADDR_W){1'b0}}, {RAM_ADDR_W{1'b1}}};

    dm_state_e         state;
    logic              t_load;
    logic [CNT_W-1:0]  t_val;
    logic              t_expired;
    logic              accept;
    logic              rom_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;

    dm_seq_fsm #(
        .RD_CYC   (RD_CYC),
        .GAP_CYC  (GAP_CYC),
        .PULSE_CYC(PULSE_CYC),
        .HOLD_CYC (HOLD_CYC),
        .CNT_W    (CNT_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_rom  (req_rom),
        .t_expired(t_expired),
        .state    (state),
        .t_load   (t_load),
        .t_val    (t_val)
    );

    dm_cycle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (t_load),
        .load_val(t_val),
        .expired (t_expired)
    );

    dm_strobe_decode u_dec (
        .state    (state),
        .rom_sel  (rom_q),
        .ram_ce_n (ram_ce_n),
        .rom_ce_n (rom_ce_n),
        .we_n     (we_n),
        .oe_n     (oe_n),
        .bus_drive(dq_oe)
    );

    assign accept = req_valid && (state == S_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rom_q   <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            rom_q   <= req_rom;
            addr_q  <= req_rom ? req_addr : (req_addr & RAM_MASK);
            wdata_q <= req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (state == S_RD_ACT && t_expired) begin
            rdata_q <= dq_in;
        end
    end

    always_comb begin
        req_ready = (state == S_IDLE);
        done      = (state == S_FINISH) || (state == S_REJECT);
        err       = (state == S_REJECT);
        rdata     = rdata_q;
        mem_addr  = addr_q;
        dq_out    = wdata_q;
    end

    AST_SELECTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ram_ce_n && !rom_ce_n)); // R2

    AST_RAM_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_ce_n |-> (mem_addr[ADDR_W-1:RAM_ADDR_W] == '0)); // R3

    AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> oe_n); // R6

    AST_WRITE_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (dq_oe && oe_n)); // R6

    AST_ROM_NEVER_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_ce_n |-> we_n); // R7

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R8

    AST_DONE_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done); // R9

endmodule

// File: tb/test_dualmem_bus_ctrl.sv
module test_dualmem_bus_ctrl;

    localparam int CLK_PERIOD = 10;
    // Expected phase lengths from the requirements at a 10 ns clock
    localparam int RD_LEN  = 10;             // ceil(100/10)
    localparam int GAP_LEN = 4;              // ceil(35/10)
    localparam int WP_LEN  = 8;              // ceil(75/10)
    localparam int LAT_RD  = RD_LEN + 1;
    localparam int LAT_WR  = GAP_LEN + 10 + 1;
    localparam int LAT_REJ = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_rom = 1'b0;
    logic [19:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, done, err;
    logic [7:0]  rdata;
    logic [19:0] mem_addr;
    logic        ram_ce_n, rom_ce_n, we_n, oe_n, dq_oe;
    logic [7:0]  dq_out;
    logic [7:0]  dq_in = 8'h5A;

    dualmem_bus_ctrl i_dualmem_bus_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_rom(req_rom), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .done(done), .err(err), .rdata(rdata),
        .mem_addr(mem_addr), .ram_ce_n(ram_ce_n), .rom_ce_n(rom_ce_n),
        .we_n(we_n), .oe_n(oe_n), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        bit         rej;
        bit         rd;
        logic [7:0] data;
        int         lat;
        int         t0;
    } exp_t;

    exp_t       sb[$];
    int         n_checks = 0;
    int         n_fail = 0;
    int         cyc = 0;
    logic [7:0] shadow[int];
    logic [7:0] dev_ram[int];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] rom_fn(input logic [19:0] a);
        return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]} ^ 8'h96;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    // Memory device model
    always @(negedge clk) begin
        if (!ram_ce_n && !we_n) dev_ram[int'(mem_addr[16:0])] = dq_out;
        if (!ram_ce_n && !oe_n)
            dq_in <= dev_ram.exists(int'(mem_addr[16:0])) ? dev_ram[int'(mem_addr[16:0])] : 8'h00;
        else if (!rom_ce_n && !oe_n)
            dq_in <= rom_fn(mem_addr);
        else
            dq_in <= 8'h5A;
    end

    // Driver: waits for ready, presents one request, pushes the expected item
    task automatic issue(input bit w, input bit rom, input logic [19:0] a, input logic [7:0] d);
        exp_t e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = w; req_rom = rom; req_addr = a; req_wdata = d;
        e.rej = w && rom;
        e.rd  = !w;
        e.t0  = cyc;
        if (w && rom)      begin e.lat = LAT_REJ; e.data = 8'h00; end
        else if (w)        begin e.lat = LAT_WR;  e.data = d; shadow[int'(a[16:0])] = d; end
        else if (rom)      begin e.lat = LAT_RD;  e.data = rom_fn(a); end
        else begin
            e.lat  = LAT_RD;
            e.data = shadow.exists(int'(a[16:0])) ? shadow[int'(a[16:0])] : 8'h00;
        end
        sb.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: completions against the scoreboard, strobe phase lengths
    int we_run = 0;
    int rd_run = 0;
    int quiet = 0;
    bit prev_dq_oe = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (done) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R8 done with no accepted request", 32'(done), 32'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(err == e.rej, "R7 err flag", 32'(err), 32'(e.rej));
                    check((cyc - e.t0) == e.lat, e.rd ? "R5 read latency" : "R6/R7 write latency",
                          32'(cyc - e.t0), 32'(e.lat));
                    if (e.rd) check(rdata == e.data, "R5 read data", 32'(rdata), 32'(e.data));
                    if (e.rej) check(ram_ce_n && rom_ce_n && we_n && oe_n && !dq_oe,
                                     "R7 reject leaves strobes idle",
                                     {27'd0, ram_ce_n, rom_ce_n, we_n, oe_n, dq_oe}, 32'h1E);
                end
            end
            if (!ram_ce_n || !rom_ce_n) begin
                check(ram_ce_n || rom_ce_n, "R2 both selects low", {30'd0, ram_ce_n, rom_ce_n}, 32'd1);
                check(!(!rom_ce_n && !we_n), "R7 ROM write strobe", 32'(we_n), 32'd1);
            end
            if (!ram_ce_n)
                check(mem_addr[19:17] == 3'b000, "R3 RAM upper address", 32'(mem_addr[19:17]), 32'd0);
            if (!we_n) we_run++;
            else if (we_run != 0) begin
                check(we_run == WP_LEN, "R6 R10 write pulse length", 32'(we_run), 32'(WP_LEN));
                we_run = 0;
            end
            if (!oe_n) rd_run++;
            else if (rd_run != 0) begin
                check(rd_run == RD_LEN, "R3 R4 read strobe length", 32'(rd_run), 32'(RD_LEN));
                rd_run = 0;
            end
            if (dq_oe && !prev_dq_oe)
                check(quiet >= GAP_LEN, "R6 turnaround gap", 32'(quiet), 32'(GAP_LEN));
            if (dq_oe) quiet = 0;
            else if (ram_ce_n && rom_ce_n && oe_n && we_n) quiet++;
            else quiet = 0;
            prev_dq_oe = dq_oe;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !done && !err, "R1 reset handshake", {29'd0, req_ready, done, err}, 32'h4);
        check(ram_ce_n && rom_ce_n && we_n && oe_n && !dq_oe, "R1 reset strobes",
              {27'd0, ram_ce_n, rom_ce_n, we_n, oe_n, dq_oe}, 32'h1E);

        // RAM writes, one with junk in the upper address bits, then read back
        issue(1'b1, 1'b0, 20'hE0123, 8'hA5);
        issue(1'b1, 1'b0, 20'h1FFFF, 8'h3C);
        issue(1'b0, 1'b0, 20'h00123, 8'h00);
        issue(1'b0, 1'b0, 20'h1FFFF, 8'h00);

        // ROM reads across the full address range
        issue(1'b0, 1'b1, 20'h00000, 8'h00);
        issue(1'b0, 1'b1, 20'hFFFFF, 8'h00);
        issue(1'b0, 1'b1, 20'h5A5A5, 8'h00);

        // Refused ROM write; RAM at the same low address stays untouched
        issue(1'b1, 1'b1, 20'h00010, 8'h77);
        issue(1'b0, 1'b0, 20'h00010, 8'h00);

        // Read followed at once by a write, then reread
        issue(1'b0, 1'b1, 20'h12345, 8'h00);
        issue(1'b1, 1'b0, 20'h00042, 8'hC3);
        issue(1'b0, 1'b0, 20'h00042, 8'h00);

        // Request while busy must be ignored
        issue(1'b0, 1'b0, 20'h00200, 8'h00);
        check(!req_ready, "R8 ready low while busy", 32'(req_ready), 32'd0);
        req_valid = 1'b1; req_write = 1'b1; req_rom = 1'b0; req_addr = 20'h00200; req_wdata = 8'hFF;
        @(negedge clk);
        req_valid = 1'b0;
        issue(1'b0, 1'b0, 20'h00200, 8'h00);

        while (sb.size() != 0) @(negedge clk);
        repeat (20) @(negedge clk);
        check(sb.size() == 0, "R9 scoreboard drained", 32'(sb.size()), 32'd0);
        check(req_ready && ram_ce_n && rom_ce_n && !dq_oe, "R1 idle after traffic",
              {28'd0, req_ready, ram_ce_n, rom_ce_n, dq_oe}, 32'hE);
        finish_run();
    end

endmodule